// File: doc/BRIEF.md
# Channel Selection and Address Responder

This block is the selection front end of a peripheral control unit on a byte-wide parallel I/O channel. Select is daisy-chained through the control units. The block watches the address byte on bus out and the channel's address out, select out and hold out tags. When the channel raises select, the block makes one of three choices:

- **Pass:** hand the select signal on to the next unit in the chain.
- **Refuse:** answer with a fixed short-busy status byte.
- **Take:** accept the selection.

When it takes a selection, it does four things:

- It latches the requested device number into a device register.
- It drives one device-select line from that register.
- It raises operational in, which interlocks the unit with the channel.
- It echoes the full address byte on bus in. It raises address in after a programmable delay that starts once the channel has dropped address out.

Operational out acts as a general reset: while it is low, every selection latch is cleared. Command handling and data transfer belong to neighbouring logic. That logic reports two things to this block. The first is whether a non-burst command is still running. The second is whether status is pending, and for which device.

Top module: `chsel_top`

## Requirements
- R1: The address byte uses bit 0 as its most significant bit (`bus_out_data[7]`). Bits 0-4 (`bus_out_data[7:3]`) hold the unit address. Bits 5-7 (`bus_out_data[2:0]`) hold the device number. A selection is considered only at a clock edge where select out, hold out and address out are all high. It is taken only when the unit is online, the unit field equals `UNIT_ADDR`, and the device number is below `NUM_DEV`.
- R2: When the unit is offline and idle, `sel_pass` follows `sel_out` in the same cycle. Three other cases cause a pass: a unit-field mismatch, an invalid device number, or select out arriving without both hold out and address out. In each of these cases `sel_pass` follows `sel_out` from the cycle after select is first sampled, until select drops. While passing, the block raises none of `opl_in`, `stat_in` or `adr_in`.
- R3: The unit is busy when `cmd_busy` is high, or when `stat_pend` is high and `stat_pend_dev` differs from the requested device. A busy unit does not take the selection. From the next cycle it raises `stat_in` with bus in = 8'h50 (bits 1 and 3 set) and P = 1, and it keeps `opl_in` low. This lasts until select out or hold out drops.
- R4: Pending status for the same device number that is being requested does not make the unit busy.
- R5: In the cycle after a selection is taken, `opl_in` is high. While it stays high, bus in carries `{UNIT_ADDR, device register}` with an odd-parity P bit, so the 9 bits hold an odd number of ones.
- R6: `adr_in` rises after `ADRIN_DLY` consecutive clock edges that sample address out low while the selection is held. If address out is seen high again, the count restarts.
- R7: On a taken selection, the device register loads the requested number, unless `dev_lock` is high and a device is already held. `dev_sel[i]` is high only when the register holds device i. The register keeps its value after disconnect until a reset.
- R8: When select out or hold out is sampled low during a held selection, `opl_in` and `adr_in` are low from the next cycle onward.
- R9: `rst` high or `opl_out` low at a clock edge clears the selection state and the device register. All response outputs and `dev_sel` are then zero.
- R10: While neither `opl_in` nor `stat_in` is high, bus in data and its P bit are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opl_out | input | 1 | Channel operational out; low clears the selection latches |
| online | input | 1 | Unit enabled for selection |
| bus_out_data | input | 8 | Channel bus out byte (bit 0 of the byte = index 7) |
| adr_out | input | 1 | Address out tag |
| sel_out | input | 1 | Select signal arriving from the chain |
| hold_out | input | 1 | Hold out tag |
| cmd_busy | input | 1 | A non-burst command is still active |
| stat_pend | input | 1 | Status is pending for an earlier operation |
| stat_pend_dev | input | 3 | Device number holding the pending status |
| dev_lock | input | 1 | A device is already selected; keep the register |
| sel_pass | output | 1 | Select propagated to the next unit |
| bus_in_data | output | 8 | Bus in byte |
| bus_in_par | output | 1 | Bus in P bit |
| stat_in | output | 1 | Status in tag |
| adr_in | output | 1 | Address in tag |
| opl_in | output | 1 | Operational in tag |
| dev_sel | output | NUM_DEV | One-hot device select lines |

## Verification
Some properties are checked on every cycle:

- Passing never goes together with a response.
- The short-busy byte is fixed, and busy never coincides with operational in.
- Bus in has odd parity while operational in is up, and is quiet when the unit is idle.
- Address in never rises while address out was high, and never without operational in.
- The device lines are at most one-hot.
- Operational in is released one cycle after select drops.
- The general reset clears everything.

Other behaviours only the bench scenarios can show:

- Which verdict each address and status combination produces.
- The exact length of the address-in delay, including its restart.
- The device register holding its value across a locked selection.
- The same-device exemption from the pending-status busy check.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
    localparam int BYTE_W = 8;
    localparam int CU_W   = 5;
    localparam int DEV_W  = 3;

    // bit 0 of a channel byte is the MSB, so the unit field sits high
    typedef struct packed {
        logic [CU_W-1:0]  cu;
        logic [DEV_W-1:0] dev;
    } addr_byte_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              par;
    } bus_byte_t;

    typedef enum logic [1:0] {
        VD_PASS = 2'd0,
        VD_BUSY = 2'd1,
        VD_TAKE = 2'd2
    } verdict_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PASS = 3'd1,
        ST_BUSY = 3'd2,
        ST_HOLD = 3'd3,
        ST_ECHO = 3'd4
    } sel_state_e;

    // busy status: bits 1 and 3 (MSB-first numbering)
    localparam logic [BYTE_W-1:0] SHORT_BUSY_BYTE = 8'h50;

    function automatic bus_byte_t odd_par_byte(input logic [BYTE_W-1:0] d);
        bus_byte_t b;
        b.data = d;
        b.par  = ~(^d);
        return b;
    endfunction
endpackage

// File: rtl/chsel_decode.sv
module chsel_decode
    import chsel_pkg::*;
#(
    parameter logic [CU_W-1:0] UNIT_ADDR = 5'h0A,
    parameter int              NUM_DEV   = 6
) (
    input  logic             online,
    input  addr_byte_t       addr,
    input  logic             cmd_busy,
    input  logic             stat_pend,
    input  logic [DEV_W-1:0] pend_dev,
    output verdict_e         verdict
);
    logic cu_hit;
    logic dev_ok;
    logic busy;

    assign cu_hit = (addr.cu == UNIT_ADDR);
    assign dev_ok = (int'(addr.dev) < NUM_DEV);
    assign busy   = cmd_busy | (stat_pend & (pend_dev != addr.dev));

    always_comb begin
        if (!online || !cu_hit || !dev_ok) verdict = VD_PASS;
        else if (busy)                     verdict = VD_BUSY;
        else                               verdict = VD_TAKE;
    end
endmodule

// File: rtl/chsel_fsm.sv
module chsel_fsm
    import chsel_pkg::*;
#(
    parameter int ADRIN_DLY = 4
) (
    input  logic       clk,
    input  logic       srst,
    input  logic       sel_out,
    input  logic       hold_out,
    input  logic       adr_out,
    input  verdict_e   verdict,
    output sel_state_e state,
    output logic       take
);
    localparam int CNT_W = $clog2(ADRIN_DLY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADRIN_DLY - 1);

    sel_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             sel_act;

    assign sel_act = sel_out & hold_out;

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sel_out) begin
                    if (!hold_out || !adr_out) state_d = ST_PASS;
                    else begin
                        unique case (verdict)
                            VD_TAKE: begin
                                state_d = ST_HOLD;
                                take    = 1'b1;
                            end
                            VD_BUSY: state_d = ST_BUSY;
                            default: state_d = ST_PASS;
                        endcase
                    end
                end
            end
            ST_PASS: if (!sel_out) state_d = ST_IDLE;
            ST_BUSY: if (!sel_act) state_d = ST_IDLE;
            ST_HOLD: begin
                if (!sel_act) state_d = ST_IDLE;
                else if (!adr_out) begin
                    if (cnt_q == CNT_LAST) state_d = ST_ECHO;
                    else                   cnt_d   = cnt_q + 1'b1;
                end
            end
            ST_ECHO: if (!sel_act) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/chsel_devreg.sv
module chsel_devreg
    import chsel_pkg::*;
#(
    parameter int NUM_DEV = 6
) (
    input  logic               clk,
    input  logic               srst,
    input  logic               take,
    input  logic               dev_lock,
    input  logic [DEV_W-1:0]   dev_in,
    output logic [DEV_W-1:0]   dev_q,
    output logic [NUM_DEV-1:0] dev_sel
);
    logic dev_vld;

    always_ff @(posedge clk) begin
        if (srst) begin
            dev_q   <= '0;
            dev_vld <= 1'b0;
        end else if (take) begin
            if (!(dev_lock && dev_vld)) dev_q <= dev_in;
            dev_vld <= 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_sel
        assign dev_sel[i] = dev_vld && (dev_q == DEV_W'(i));
    end
endmodule

// File: rtl/chsel_top.sv
module chsel_top
    import chsel_pkg::*;
#(
    parameter logic [4:0] UNIT_ADDR = 5'h0A,
    parameter int         ADRIN_DLY = 4,
    parameter int         NUM_DEV   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               opl_out,
    input  logic               online,
    input  logic [7:0]         bus_out_data,
    input  logic               adr_out,
    input  logic               sel_out,
    input  logic               hold_out,
    input  logic               cmd_busy,
    input  logic               stat_pend,
    input  logic [2:0]         stat_pend_dev,
    input  logic               dev_lock,
    output logic               sel_pass,
    output logic [7:0]         bus_in_data,
    output logic               bus_in_par,
    output logic               stat_in,
    output logic               adr_in,
    output logic               opl_in,
    output logic [NUM_DEV-1:0] dev_sel
);
    addr_byte_t       addr;
    verdict_e         verdict;
    sel_state_e       state;
    logic             take;
    logic             srst;
    logic [DEV_W-1:0] dev_q;
    bus_byte_t        drive;

    assign addr = addr_byte_t'(bus_out_data);
    assign srst = rst | ~opl_out;

    chsel_decode #(.UNIT_ADDR(UNIT_ADDR), .NUM_DEV(NUM_DEV)) u_decode (
        .online   (online),
        .addr     (addr),
        .cmd_busy (cmd_busy),
        .stat_pend(stat_pend),
        .pend_dev (stat_pend_dev),
        .verdict  (verdict)
    );

    chsel_fsm #(.ADRIN_DLY(ADRIN_DLY)) u_fsm (
        .clk     (clk),
        .srst    (srst),
        .sel_out (sel_out),
        .hold_out(hold_out),
        .adr_out (adr_out),
        .verdict (verdict),
        .state   (state),
        .take    (take)
    );

    chsel_devreg #(.NUM_DEV(NUM_DEV)) u_devreg (
        .clk     (clk),
        .srst    (srst),
        .take    (take),
        .dev_lock(dev_lock),
        .dev_in  (addr.dev),
        .dev_q   (dev_q),
        .dev_sel (dev_sel)
    );

    // offline relay path is immediate; decoded bypass is registered
    assign sel_pass = sel_out & (((state == ST_IDLE) & ~online) | (state == ST_PASS));
    assign stat_in  = (state == ST_BUSY);
    assign opl_in   = (state == ST_HOLD) | (state == ST_ECHO);
    assign adr_in   = (state == ST_ECHO);

    always_comb begin
        drive = '0;
        if (stat_in)     drive = odd_par_byte(SHORT_BUSY_BYTE);
        else if (opl_in) drive = odd_par_byte({UNIT_ADDR, dev_q});
    end

    assign bus_in_data = drive.data;
    assign bus_in_par  = drive.par;
endmodule

// File: rtl/chsel_checker.sv
module chsel_checker #(
    parameter int NUM_DEV = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               opl_out,
    input logic               adr_out,
    input logic               sel_out,
    input logic               hold_out,
    input logic               sel_pass,
    input logic [7:0]         bus_in_data,
    input logic               bus_in_par,
    input logic               stat_in,
    input logic               adr_in,
    input logic               opl_in,
    input logic [NUM_DEV-1:0] dev_sel
);
    assert_pass_silent_R2: assert property (@(posedge clk) disable iff (rst)
        sel_pass |-> (!opl_in && !stat_in && !adr_in));

    assert_busy_byte_R3: assert property (@(posedge clk) disable iff (rst)
        stat_in |-> (bus_in_data == 8'h50 && bus_in_par));

    assert_busy_no_opl_R3: assert property (@(posedge clk) disable iff (rst)
        stat_in |-> !opl_in);

    assert_odd_par_R5: assert property (@(posedge clk) disable iff (rst)
        opl_in |-> (^{bus_in_data, bus_in_par}));

    assert_adrin_opl_R6: assert property (@(posedge clk) disable iff (rst)
        adr_in |-> opl_in);

    assert_adrin_after_drop_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(adr_in) |-> !$past(adr_out));

    assert_devsel_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_sel));

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        (opl_in && !(sel_out && hold_out)) |=> !opl_in);

    assert_oplout_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !opl_out |=> (!opl_in && !stat_in && !adr_in && dev_sel == '0));

    assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (rst)
        !(opl_in || stat_in) |-> (bus_in_data == 8'h00 && !bus_in_par));
endmodule

bind chsel_top chsel_checker #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .opl_out    (opl_out),
    .adr_out    (adr_out),
    .sel_out    (sel_out),
    .hold_out   (hold_out),
    .sel_pass   (sel_pass),
    .bus_in_data(bus_in_data),
    .bus_in_par (bus_in_par),
    .stat_in    (stat_in),
    .adr_in     (adr_in),
    .opl_in     (opl_in),
    .dev_sel    (dev_sel)
);

// File: tb/chsel_top_bench.sv
module chsel_top_bench;
    localparam logic [4:0] UA  = 5'h0A;
    localparam int         DLY = 3;
    localparam int         ND  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic opl_out = 1'b0, online = 1'b1;
    logic [7:0] bus_out_data = 8'h00;
    logic adr_out = 1'b0, sel_out = 1'b0, hold_out = 1'b0;
    logic cmd_busy = 1'b0, stat_pend = 1'b0, dev_lock = 1'b0;
    logic [2:0] stat_pend_dev = 3'd0;
    logic sel_pass, bus_in_par, stat_in, adr_in, opl_in;
    logic [7:0] bus_in_data;
    logic [ND-1:0] dev_sel;

    int total = 0;
    int bad = 0;
    bit cmp_on = 0;

    always #2 clk = ~clk;

    chsel_top #(.UNIT_ADDR(UA), .ADRIN_DLY(DLY), .NUM_DEV(ND)) u_chsel_top (
        .clk(clk), .rst(rst), .opl_out(opl_out), .online(online),
        .bus_out_data(bus_out_data), .adr_out(adr_out), .sel_out(sel_out),
        .hold_out(hold_out), .cmd_busy(cmd_busy), .stat_pend(stat_pend),
        .stat_pend_dev(stat_pend_dev), .dev_lock(dev_lock),
        .sel_pass(sel_pass), .bus_in_data(bus_in_data), .bus_in_par(bus_in_par),
        .stat_in(stat_in), .adr_in(adr_in), .opl_in(opl_in), .dev_sel(dev_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 idle, 1 passing, 2 busy, 3 selected, 4 address in
    int ms = 0, mcnt = 0, mdev = 0;
    bit mvld = 0;

    always @(posedge clk) begin
        int cu, dv;
        cu = int'(bus_out_data[7:3]);
        dv = int'(bus_out_data[2:0]);
        if (rst || !opl_out) begin
            ms = 0; mcnt = 0; mdev = 0; mvld = 0;
        end else begin
            case (ms)
                0: if (sel_out) begin
                    if (!hold_out || !adr_out || !online || cu != int'(UA) || dv >= ND) ms = 1;
                    else if (cmd_busy || (stat_pend && int'(stat_pend_dev) != dv)) ms = 2;
                    else begin
                        ms = 3; mcnt = 0;
                        if (!(dev_lock && mvld)) mdev = dv;
                        mvld = 1;
                    end
                end
                1: if (!sel_out) ms = 0;
                2: if (!(sel_out && hold_out)) ms = 0;
                3: if (!(sel_out && hold_out)) begin ms = 0; mcnt = 0; end
                   else if (adr_out) mcnt = 0;
                   else begin
                       mcnt++;
                       if (mcnt == DLY) begin ms = 4; mcnt = 0; end
                   end
                default: if (!(sel_out && hold_out)) ms = 0;
            endcase
        end
        #1;
        if (cmp_on) begin
            int eb, ep;
            eb = 0; ep = 0;
            if (ms == 2) begin eb = 8'h50; ep = 1; end
            else if (ms >= 3) begin
                eb = (int'(UA) << 3) | mdev;
                ep = ($countones(eb) % 2 == 0) ? 1 : 0;
            end
            chk("R2 sel_pass", int'(sel_pass), int'(sel_out && ((ms == 0 && !online) || ms == 1)));
            chk("R3 stat_in", int'(stat_in), int'(ms == 2));
            chk("R5 opl_in", int'(opl_in), int'(ms >= 3));
            chk("R6 adr_in", int'(adr_in), int'(ms == 4));
            chk("R10 bus_in_data", int'(bus_in_data), eb);
            chk("R10 bus_in_par", int'(bus_in_par), ep);
            chk("R7 dev_sel", int'(dev_sel), mvld ? (1 << mdev) : 0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic select(input logic [4:0] cu, input logic [2:0] dv);
        @(negedge clk);
        bus_out_data = {cu, dv};
        adr_out = 1'b1; hold_out = 1'b1; sel_out = 1'b1;
    endtask

    task automatic drop_all();
        @(negedge clk);
        sel_out = 1'b0; hold_out = 1'b0; adr_out = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(2);
        cmp_on = 1;
        @(negedge clk); rst = 1'b0; opl_out = 1'b1;
        tick(1);
        // R9 R10: reset state
        chk("R9 opl_in after reset", int'(opl_in), 0);
        chk("R9 dev_sel after reset", int'(dev_sel), 0);
        chk("R10 bus quiet after reset", int'({bus_in_data, bus_in_par}), 0);

        // R1 R5 R6 R7 R8: take selection of device 2
        select(UA, 3'd2);
        tick(1);
        chk("R1 taken", int'(opl_in), 1);
        chk("R5 echo byte", int'(bus_in_data), 8'h52);
        chk("R5 echo parity", int'(bus_in_par), 0);
        chk("R7 dev_sel dev2", int'(dev_sel), 6'b000100);
        @(negedge clk); adr_out = 1'b0;
        tick(DLY - 1);
        chk("R6 adr_in early", int'(adr_in), 0);
        tick(1);
        chk("R6 adr_in on time", int'(adr_in), 1);
        drop_all();
        tick(1);
        chk("R8 released", int'(opl_in), 0);
        chk("R7 kept after release", int'(dev_sel), 6'b000100);

        // R2: unit field mismatch
        select(5'h0B, 3'd1);
        #1;
        chk("R2 no pass same cycle online", int'(sel_pass), 0);
        tick(1);
        chk("R2 mismatch passes", int'(sel_pass), 1);
        chk("R2 mismatch silent", int'(opl_in | stat_in), 0);
        drop_all(); tick(1);

        // R1: device number 6 invalid
        select(UA, 3'd6);
        tick(1);
        chk("R1 bad device passes", int'(sel_pass), 1);
        drop_all(); tick(1);

        // R2: offline passes immediately
        @(negedge clk); online = 1'b0;
        select(UA, 3'd1);
        #1;
        chk("R2 offline pass immediate", int'(sel_pass), 1);
        tick(1);
        chk("R2 offline no response", int'(opl_in), 0);
        drop_all(); @(negedge clk); online = 1'b1; tick(1);

        // R3: command busy
        @(negedge clk); cmd_busy = 1'b1;
        select(UA, 3'd1);
        tick(1);
        chk("R3 busy stat_in", int'(stat_in), 1);
        chk("R3 busy byte", int'({bus_in_data, bus_in_par}), 9'h0A1);
        chk("R3 busy no opl_in", int'(opl_in), 0);
        drop_all(); @(negedge clk); cmd_busy = 1'b0;
        tick(1);
        chk("R3 busy ends", int'(stat_in), 0);

        // R3 R4: pending status on device 3
        @(negedge clk); stat_pend = 1'b1; stat_pend_dev = 3'd3;
        select(UA, 3'd1);
        tick(1);
        chk("R3 pend other device busy", int'(stat_in), 1);
        drop_all(); tick(1);
        select(UA, 3'd3);
        tick(1);
        chk("R4 pend same device taken", int'(opl_in), 1);
        chk("R4 dev_sel dev3", int'(dev_sel), 6'b001000);
        drop_all(); @(negedge clk); stat_pend = 1'b0; tick(1);

        // R7: locked register keeps device 3
        @(negedge clk); dev_lock = 1'b1;
        select(UA, 3'd4);
        tick(1);
        chk("R7 lock keeps device", int'(dev_sel), 6'b001000);
        chk("R7 lock echo", int'(bus_in_data), 8'h53);
        drop_all(); @(negedge clk); dev_lock = 1'b0; tick(1);

        // R6: address out rising again restarts the delay
        select(UA, 3'd0);
        tick(1);
        @(negedge clk); adr_out = 1'b0;
        tick(DLY - 1);
        @(negedge clk); adr_out = 1'b1;
        tick(1);
        @(negedge clk); adr_out = 1'b0;
        tick(DLY - 1);
        chk("R6 restart no early adr_in", int'(adr_in), 0);
        tick(1);
        chk("R6 restart adr_in", int'(adr_in), 1);

        // R9: operational out low mid-selection
        @(negedge clk); opl_out = 1'b0;
        tick(1);
        chk("R9 opl_out clears opl_in", int'(opl_in), 0);
        chk("R9 opl_out clears dev_sel", int'(dev_sel), 0);
        drop_all(); @(negedge clk); opl_out = 1'b1; tick(1);

        // R8: select without hold out is passed
        @(negedge clk);
        bus_out_data = {UA, 3'd1}; adr_out = 1'b1; sel_out = 1'b1; hold_out = 1'b0;
        tick(1);
        chk("R8 no hold passes", int'(sel_pass), 1);
        chk("R8 no hold no opl_in", int'(opl_in), 0);
        drop_all(); tick(3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule